// File: doc/BRIEF.md
# Periodic Interrupt Split-Transaction Sequencer

This block runs one queue head of a high-speed host through the two phases of a full- or low-speed interrupt split transaction. The host schedule logic pulses `slot` once per micro-frame, with the frame index present. When the queue head is idle in its start phase and its start mask selects the current micro-frame, the block issues a start-split. It records the frame number and clears its progress record, then moves to the complete phase without waiting for any handshake.

In the complete phase the block issues a complete-split only in a micro-frame that satisfies three tests. The complete mask must select that micro-frame. The previous complete slot must have been attempted, or this must be the first complete slot. The frame number must agree with the recorded tag. Each issued complete-split waits for a result code from the bus engine. The code sends the queue head back to the start phase, keeps it in the complete phase, retries at once, or halts it. A two-bit strike counter halts the endpoint after three transaction errors. Fatal codes halt it at once. Software clears a halt with `init`.

Top module: `split_xact_fsm`

## Requirements
- R1: After reset or a one-cycle `init` pulse, no request is issued, `in_cpl` and `halted` are 0, `err_cnt` is 3 and `prog_mask` is 8'h00.
- R2: The micro-frame number is `frindex[2:0]`, decoded one-hot (micro-frame 0 selects bit 0). In the start phase, a `slot` pulse whose micro-frame bit is set in `s_mask` makes `ss_req` high for exactly the following cycle. Any other `slot` leaves the block idle. `ss_req` and `cs_req` are never high together.
- R3: The cycle after a start-split, `in_cpl` is 1 and `prog_mask` is 8'h00. `frame_tag` holds the `frindex[7:3]` value of the start slot.
- R4: In the complete phase, a `slot` pulse raises `cs_req` for the following cycle only when three tests pass: `c_mask` has the current micro-frame bit set, the R5 check passes, and the frame number matches. The frame number is `frindex[7:3]`. It must equal `frame_tag` when the current micro-frame index is above the start micro-frame index. Otherwise it must equal `frame_tag`+1 modulo 32.
- R5: The previous-slot check passes when the lowest set bit of `c_mask` is the current micro-frame. It also passes when the micro-frame before the current one (modulo 8) is set in both `c_mask` and `prog_mask`.
- R6: An issued complete-split ORs the current micro-frame bit into `prog_mask`. Until a result arrives, `slot` pulses are ignored.
- R7: While a result is awaited, `res_valid` with `res_code` 0 (complete) returns the block to the start phase. Codes 1 (NYET) and 2 (MDATA) return it to the complete phase. Code 7 is ignored.
- R8: Code 3 (transaction error) decrements `err_cnt`. If the count reaches 0, the block halts. Otherwise `cs_req` is high in the next cycle as an immediate retry, and the block keeps waiting.
- R9: Codes 4 (babble), 5 (data loss) and 6 (STALL) halt the block. While halted, `halted` stays 1 and no request is issued until `init`.
- R10: `res_valid` is ignored when no result is awaited. When a result and a `slot` arrive in the same cycle while a result is awaited, only the result is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Software reinitialisation, synchronous |
| slot | input | 1 | One pulse per micro-frame evaluation |
| frindex | input | FIDX_W | Frame index; [2:0] micro-frame, [7:3] frame number |
| s_mask | input | 8 | Start-split micro-frame mask |
| c_mask | input | 8 | Complete-split micro-frame mask |
| res_valid | input | 1 | Result code strobe |
| res_code | input | 3 | Result of the last complete-split |
| ss_req | output | 1 | Start-split request pulse |
| cs_req | output | 1 | Complete-split request pulse |
| in_cpl | output | 1 | Queue head is in the complete phase |
| halted | output | 1 | Endpoint halted |
| err_cnt | output | 2 | Strike counter |
| prog_mask | output | 8 | Complete-split progress mask |
| frame_tag | output | 5 | Frame tag recorded at start-split |

## Verification
A micro-frame strobe and a result code can arrive in the same cycle. That cycle could then hold both a phase decision and a slot evaluation. The bench provokes this on purpose: a complete result arrives together with a slot whose micro-frame is set in the start mask. The pass condition is that no start-split follows, that the block sits in the start phase afterwards, and that the next matching slot does issue the start-split. The same collision is judged with an ignored code 7, where the slot must also be dropped. A bench model written from the requirements scores every step, across sweeps of start micro-frame, complete-mask placement with frame wrap, and every result code.

// File: rtl/split_xact_fsm.sv
module split_xact_fsm #(
  parameter int         FIDX_W    = 14,
  parameter logic [1:0] CERR_INIT = 2'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              slot,
  input  logic [FIDX_W-1:0] frindex,
  input  logic [7:0]        s_mask,
  input  logic [7:0]        c_mask,
  input  logic              res_valid,
  input  logic [2:0]        res_code,
  output logic              ss_req,
  output logic              cs_req,
  output logic              in_cpl,
  output logic              halted,
  output logic [1:0]        err_cnt,
  output logic [7:0]        prog_mask,
  output logic [4:0]        frame_tag
);
  typedef enum logic [1:0] {ST_START, ST_CPL, ST_WAIT, ST_HALT} st_t;

  localparam logic [2:0] RC_DONE = 3'd0, RC_NYET = 3'd1, RC_MDATA = 3'd2, RC_XERR = 3'd3,
                         RC_BABBLE = 3'd4, RC_DLOSS = 3'd5, RC_STALL = 3'd6;

  st_t        st;
  logic [2:0] uf, prev_uf, ss_uf;
  logic [7:0] ubit, cm_low;
  logic [4:0] fr, tag_want;
  logic       prev_ok, tag_ok, ss_go, cs_go;

  assign uf       = frindex[2:0];
  assign fr       = frindex[7:3];
  assign ubit     = 8'd1 << uf;
  assign prev_uf  = uf - 3'd1;
  assign cm_low   = c_mask & (~c_mask + 8'd1);
  assign prev_ok  = (cm_low == ubit) || (prog_mask[prev_uf] && c_mask[prev_uf]);
  assign tag_want = (uf > ss_uf) ? frame_tag : 5'(frame_tag + 5'd1);
  assign tag_ok   = (fr == tag_want);
  assign ss_go    = slot && |(s_mask & ubit);
  assign cs_go    = slot && |(c_mask & ubit) && prev_ok && tag_ok;

  assign halted = (st == ST_HALT);
  assign in_cpl = (st == ST_CPL) || (st == ST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_START;
      err_cnt   <= CERR_INIT;
      prog_mask <= 8'h00;
      frame_tag <= 5'd0;
      ss_uf     <= 3'd0;
      ss_req    <= 1'b0;
      cs_req    <= 1'b0;
    end else if (init) begin
      st        <= ST_START;
      err_cnt   <= CERR_INIT;
      prog_mask <= 8'h00;
      frame_tag <= 5'd0;
      ss_uf     <= 3'd0;
      ss_req    <= 1'b0;
      cs_req    <= 1'b0;
    end else begin
      ss_req <= 1'b0;
      cs_req <= 1'b0;
      case (st)
        ST_START: if (ss_go) begin
          ss_req    <= 1'b1;
          prog_mask <= 8'h00;
          frame_tag <= fr;
          ss_uf     <= uf;
          st        <= ST_CPL;
        end
        ST_CPL: if (cs_go) begin
          cs_req    <= 1'b1;
          prog_mask <= prog_mask | ubit;
          st        <= ST_WAIT;
        end
        ST_WAIT: if (res_valid) begin
          case (res_code)
            RC_DONE:           st <= ST_START;
            RC_NYET, RC_MDATA: st <= ST_CPL;
            RC_XERR: begin
              if (err_cnt <= 2'd1) begin
                err_cnt <= 2'd0;
                st      <= ST_HALT;
              end else begin
                err_cnt <= err_cnt - 2'd1;
                cs_req  <= 1'b1;
              end
            end
            RC_BABBLE, RC_DLOSS, RC_STALL: st <= ST_HALT;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/split_xact_fsm_chk.sv
module split_xact_fsm_chk #(
  parameter int FIDX_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init,
  input logic              slot,
  input logic [FIDX_W-1:0] frindex,
  input logic [7:0]        s_mask,
  input logic [7:0]        c_mask,
  input logic              res_valid,
  input logic              ss_req,
  input logic              cs_req,
  input logic              in_cpl,
  input logic              halted,
  input logic [1:0]        err_cnt,
  input logic [7:0]        prog_mask
);
  AST_SS_ON_SMASK: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> $past(slot) && $past(s_mask[frindex[2:0]])); // R2
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ss_req, cs_req})); // R2
  AST_SS_ENTERS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> in_cpl && prog_mask == 8'h00); // R3
  AST_CS_ON_CMASK: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req && !$past(res_valid) |-> $past(slot) && $past(c_mask[frindex[2:0]])); // R4
  AST_CS_MARKS_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    cs_req && !$past(res_valid) |-> prog_mask[$past(frindex[2:0])]); // R6
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != $past(err_cnt)) && !$past(init) |-> err_cnt == 2'($past(err_cnt) - 2'd1)); // R8
  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !ss_req && !cs_req); // R9
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !init |=> halted); // R9
endmodule

bind split_xact_fsm split_xact_fsm_chk #(.FIDX_W(FIDX_W)) u_chk (.*);

// File: tb/tb_split_xact_fsm.sv
module tb_split_xact_fsm;
  logic        clk = 1'b0, rst_n = 1'b0, init = 1'b0, slot = 1'b0, res_valid = 1'b0;
  logic [13:0] frindex = '0;
  logic [7:0]  s_mask = '0, c_mask = '0;
  logic [2:0]  res_code = '0;
  logic        ss_req, cs_req, in_cpl, halted;
  logic [1:0]  err_cnt;
  logic [7:0]  prog_mask;
  logic [4:0]  frame_tag;

  int n_run = 0, n_fail = 0;
  int m_st;                     // 0 start, 1 complete, 2 waiting, 3 halted
  logic [7:0] m_prog;
  logic [4:0] m_tag;
  logic [2:0] m_ssuf;
  logic [1:0] m_err;

  always #5 clk = ~clk;

  split_xact_fsm dut (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic m_reset();
    m_st = 0; m_prog = 8'h00; m_tag = 5'd0; m_ssuf = 3'd0; m_err = 2'd3;
  endtask

  function automatic logic [31:0] packed_out();
    return {18'd0, ss_req, cs_req, in_cpl, halted, err_cnt, prog_mask};
  endfunction

  function automatic logic [31:0] packed_exp(input logic es, input logic ec);
    return {18'd0, es, ec, (m_st == 1 || m_st == 2), (m_st == 3), m_err, m_prog};
  endfunction

  task automatic do_init(input string r);
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    m_reset();
    chk(r, packed_out(), packed_exp(1'b0, 1'b0));
  endtask

  task automatic apply(input string r, input logic ds, input logic [13:0] f,
                       input logic dr, input logic [2:0] code);
    logic es, ec;
    int lo;
    logic [2:0] uf, pu;
    logic [4:0] want;
    es = 1'b0; ec = 1'b0;
    uf = f[2:0];
    if (m_st == 2) begin
      if (dr) begin
        case (code)
          3'd0: m_st = 0;
          3'd1, 3'd2: m_st = 1;
          3'd3: if (m_err == 2'd1) begin m_err = 2'd0; m_st = 3; end
                else begin m_err = m_err - 2'd1; ec = 1'b1; end
          3'd4, 3'd5, 3'd6: m_st = 3;
          default: ;
        endcase
      end
    end else if (m_st == 0 && ds && s_mask[uf]) begin
      es = 1'b1; m_prog = 8'h00; m_tag = f[7:3]; m_ssuf = uf; m_st = 1;
    end else if (m_st == 1 && ds) begin
      lo = -1;
      for (int i = 7; i >= 0; i--) if (c_mask[i]) lo = i;
      pu = uf - 3'd1;
      want = (uf > m_ssuf) ? m_tag : 5'(m_tag + 5'd1);
      if (c_mask[uf] && (lo == int'(uf) || (m_prog[pu] && c_mask[pu])) && f[7:3] == want) begin
        ec = 1'b1; m_prog = m_prog | (8'd1 << uf); m_st = 2;
      end
    end
    @(negedge clk);
    slot = ds; frindex = f; res_valid = dr; res_code = code;
    @(negedge clk);
    slot = 1'b0; res_valid = 1'b0;
    chk(r, packed_out(), packed_exp(es, ec));
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset", packed_out(), packed_exp(1'b0, 1'b0));

    // R2 R3: every start bit against every micro-frame
    for (int s = 0; s < 8; s++) begin
      for (int u = 0; u < 8; u++) begin
        s_mask = 8'd1 << s; c_mask = 8'h00;
        do_init("R1 init");
        apply("R2 start sweep", 1'b1, 14'(8 * 9 + u), 1'b0, 3'd0);
        if (s == u) chk("R3 frame tag", 32'(frame_tag), 32'd9);
      end
    end

    // R4 R5 R6 R7: complete walk with frame wrap, per start slot
    for (int s = 0; s < 8; s++) begin
      logic [13:0] f;
      s_mask = 8'd1 << s;
      c_mask = (8'd1 << ((s + 2) % 8)) | (8'd1 << ((s + 3) % 8)) | (8'd1 << ((s + 4) % 8));
      do_init("R1 init");
      f = 14'(40 + s);
      apply("R2 start", 1'b1, f, 1'b0, 3'd0);
      for (int k = 1; k <= 6; k++) begin
        f = f + 14'd1;
        apply("R4 complete walk", 1'b1, f, 1'b0, 3'd0);
        if (m_st == 2)
          apply("R7 result", 1'b0, f, 1'b1, (int'(f[2:0]) == (s + 4) % 8) ? 3'd0 : 3'd1);
      end
    end

    // R5: skipped complete slot blocks later ones
    s_mask = 8'h02; c_mask = 8'h38;
    do_init("R1 init");
    apply("R2 start", 1'b1, 14'd9, 1'b0, 3'd0);
    apply("R5 skipped slot", 1'b1, 14'd12, 1'b0, 3'd0);
    apply("R5 skipped slot", 1'b1, 14'd13, 1'b0, 3'd0);

    // R4: frame number mismatch, then match
    do_init("R1 init");
    apply("R2 start", 1'b1, 14'd9, 1'b0, 3'd0);
    apply("R4 tag mismatch", 1'b1, 14'd19, 1'b0, 3'd0);
    apply("R4 tag match", 1'b1, 14'd11, 1'b0, 3'd0);
    // R6: slot while waiting ignored; R7 code 7 ignored; MDATA back to complete
    apply("R6 slot while waiting", 1'b1, 14'd12, 1'b0, 3'd0);
    apply("R7 code 7 ignored", 1'b0, 14'd12, 1'b1, 3'd7);
    apply("R7 mdata", 1'b0, 14'd12, 1'b1, 3'd2);
    apply("R6 next complete", 1'b1, 14'd12, 1'b0, 3'd0);
    apply("R7 done", 1'b0, 14'd12, 1'b1, 3'd0);
    apply("R2 restart", 1'b1, 14'd17, 1'b0, 3'd0);
    // R10: result while not waiting ignored
    apply("R10 stray result", 1'b0, 14'd17, 1'b1, 3'd4);

    // R8 R9: three strikes
    s_mask = 8'h01; c_mask = 8'h04;
    do_init("R1 init");
    apply("R2 start", 1'b1, 14'd0, 1'b0, 3'd0);
    apply("R4 complete", 1'b1, 14'd2, 1'b0, 3'd0);
    apply("R8 strike one retry", 1'b0, 14'd2, 1'b1, 3'd3);
    apply("R8 strike two retry", 1'b0, 14'd2, 1'b1, 3'd3);
    apply("R8 strike three halt", 1'b0, 14'd2, 1'b1, 3'd3);
    apply("R9 halted slot", 1'b1, 14'd8, 1'b0, 3'd0);
    apply("R9 halted result", 1'b0, 14'd8, 1'b1, 3'd0);
    do_init("R9 init clears halt");
    apply("R9 after init", 1'b1, 14'd8, 1'b0, 3'd0);

    // R9: fatal codes
    for (int c = 4; c <= 6; c++) begin
      do_init("R1 init");
      apply("R2 start", 1'b1, 14'd0, 1'b0, 3'd0);
      apply("R4 complete", 1'b1, 14'd2, 1'b0, 3'd0);
      apply("R9 fatal code", 1'b0, 14'd2, 1'b1, 3'(c));
      apply("R9 stays halted", 1'b1, 14'd8, 1'b0, 3'd0);
    end

    // R10: result and slot in the same cycle while waiting
    do_init("R1 init");
    apply("R2 start", 1'b1, 14'd0, 1'b0, 3'd0);
    apply("R4 complete", 1'b1, 14'd2, 1'b0, 3'd0);
    apply("R10 collide done", 1'b1, 14'd8, 1'b1, 3'd0);
    apply("R10 next start", 1'b1, 14'd16, 1'b0, 3'd0);
    apply("R4 complete", 1'b1, 14'd18, 1'b0, 3'd0);
    apply("R10 collide code 7", 1'b1, 14'd18, 1'b1, 3'd7);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule